// File: doc/BRIEF.md
# Gated-Write Board Control Register

This block is a small byte-wide register file for a board-management logic device. A host reaches it over a plain 8-bit peripheral bus with an address, a one-cycle write strobe, a one-cycle read strobe and a data byte. It offers three registers: a fixed revision byte, a byte that shows the board's status input lines after synchronisation, and a control byte. The control byte drives two outputs, an active-low POST indicator LED and an active-low reset line to a carrier board.

Every control flag has its own gate bit in the same byte. A write changes a flag only when that flag's gate bit is 1 in the written data. Software can therefore move one output with a single store and leave the other untouched, with no read-modify-write. Registers sit on 32-bit aligned offsets, and any byte that no register occupies reads as zero.

Read data is registered. It appears on the bus the cycle after the read strobe and is zero in every other cycle.

Top module: `bctl_regs`

## Requirements
- R1: After a synchronous reset, `post_led_n` is 0 (LED lit), `carrier_rst_n` is 1 (inactive), and the control register reads 0x40.
- R2: A read at offset 0 returns the revision parameter in bits 3:0, with bits 7:4 equal to 0.
- R3: A read at offset 4 returns the `stat_in` levels, zero-extended to 8 bits, once they have passed a two-flop synchronizer. A level that is applied before an edge is visible to a read strobe sampled two edges later.
- R4: A write at offset 8 with data bit 1 set loads data bit 0 into the POST LED flag, which drives `post_led_n` from the next clock edge.
- R5: A write at offset 8 with data bit 1 clear leaves the POST LED flag unchanged, whatever data bit 0 holds.
- R6: A write at offset 8 with data bit 7 set loads data bit 6 into the reset flag. The value 0x80 drives `carrier_rst_n` low, and 0xC0 drives it high.
- R7: A write at offset 8 with data bit 7 clear leaves the reset flag unchanged. A write that gates only one flag never alters the other.
- R8: A read at offset 8 returns the LED flag in bit 0 and the reset flag in bit 6 (1 = inactive). The gate bits 1 and 7 and the bits 2 to 5 read as 0.
- R9: Writes to offsets 0 and 4, or to any unmapped offset, change neither output nor any register value.
- R10: A read at any offset other than 0, 4 or 8 returns 0x00.
- R11: `bus_rdata` carries the selected byte in the cycle after a read strobe, and 0x00 in any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| stat_in | input | STAT_W | Asynchronous board status lines |
| post_led_n | output | 1 | POST LED drive, active low |
| carrier_rst_n | output | 1 | Reset output to the carrier board, active low |

## Verification
The gated write is driven with every combination of the gate and flag bits for both flags: gate set with flag 0, gate set with flag 1, flag set without its gate, and one gate set while the other flag's bit carries a value that differs from that flag's current state. These patterns separate a correct gate from a missing gate, from a swapped gate, and from a write that leaks into the neighbouring flag. Control read-backs after each step show that the gate bits never read back as 1. Writes to the revision offset, the status offset and an unmapped offset, followed by read-backs, separate a full address decode from one that looks only at the low bits. Two different status patterns show that the synchronized value is really sampled and not fixed.

// File: rtl/bctl_pkg.sv
package bctl_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_FLAGS = 2;

    // Byte offsets of the three registers (32-bit aligned)
    localparam int unsigned OFS_VERSION = 0;
    localparam int unsigned OFS_STATUS  = 4;
    localparam int unsigned OFS_CONTROL = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_VER  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // Bit that holds control flag i (0: POST LED, 1: carrier reset)
    function automatic int flag_bit(input int i);
        return (i == 0) ? 0 : 6;
    endfunction

    // Gate bit that enables an update of control flag i
    function automatic int gate_bit(input int i);
        return (i == 0) ? 1 : 7;
    endfunction

    // Value of control flag i after reset
    function automatic logic flag_rst(input int i);
        return (i == 0) ? 1'b0 : 1'b1;
    endfunction

    // Map a byte offset to a register select
    function automatic reg_sel_e decode(input int unsigned ofs);
        if (ofs == OFS_VERSION) return SEL_VER;
        if (ofs == OFS_STATUS)  return SEL_STAT;
        if (ofs == OFS_CONTROL) return SEL_CTRL;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/bctl_sync.sv
// Two-flop synchronizer for a bundle of slow, independent level inputs.
// Assumes each bit is quasi-static, so no cross-bit coherency is needed.
module bctl_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Shift the inputs through two flops; clear both on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/bctl_gated_flag.sv
// One control flag whose update needs its gate bit set in the same write.
// Assumes wr_ctrl is already qualified by the control offset decode.
module bctl_gated_flag
    import bctl_pkg::*;
#(
    parameter int   FLAG_POS = 0,
    parameter int   GATE_POS = 1,
    parameter logic RST_VAL  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    output logic              flag
);
    logic load;

    // The flag moves only when its own gate bit is written as 1
    always_comb load = wr_ctrl && wdata[GATE_POS];

    // Hold the flag; take the written value on a gated write
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= RST_VAL;
        else if (load) flag <= wdata[FLAG_POS];
    end
endmodule

// File: rtl/bctl_rd_mux.sv
// Combinational read selection of the three registers.
// Assumes STAT_W <= 8 and that unused bits and offsets must read as zero.
module bctl_rd_mux
    import bctl_pkg::*;
#(
    parameter int         STAT_W  = 4,
    parameter logic [3:0] VERSION = 4'h3
) (
    input  reg_sel_e           sel,
    input  logic [STAT_W-1:0]  stat,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [BYTE_W-1:0]  rdata
);
    logic [BYTE_W-1:0] ctrl_byte;

    // Place each flag at its bit; gate and spare bits stay 0
    always_comb begin
        ctrl_byte = '0;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            ctrl_byte[flag_bit(i)] = flags[i];
        end
    end

    // Pick the byte for the addressed register
    always_comb begin
        unique case (sel)
            SEL_VER:  rdata = BYTE_W'(VERSION);
            SEL_STAT: rdata = BYTE_W'(stat);
            SEL_CTRL: rdata = ctrl_byte;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/bctl_regs.sv
// Byte-wide board control register block on a single-cycle peripheral bus.
// Assumes strobes are one cycle wide and synchronous to clk; read data is
// registered and valid the cycle after bus_rd, zero otherwise.
module bctl_regs
    import bctl_pkg::*;
#(
    parameter int         ADDR_W  = 4,
    parameter int         STAT_W  = 4,
    parameter logic [3:0] VERSION = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [STAT_W-1:0] stat_in,
    output logic              post_led_n,
    output logic              carrier_rst_n
);
    reg_sel_e             sel;
    logic                 wr_ctrl;
    logic [STAT_W-1:0]    stat_sync;
    logic [NUM_FLAGS-1:0] flags;
    logic [BYTE_W-1:0]    rd_next;

    // Decode the full offset into a register select
    always_comb sel = decode(32'(bus_addr));

    // Qualify a write with the control offset; other writes are dropped
    always_comb wr_ctrl = bus_wr && (sel == SEL_CTRL);

    bctl_sync #(.W(STAT_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stat_in),
        .q     (stat_sync)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        bctl_gated_flag #(
            .FLAG_POS (flag_bit(g)),
            .GATE_POS (gate_bit(g)),
            .RST_VAL  (flag_rst(g))
        ) u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_ctrl),
            .wdata   (bus_wdata),
            .flag    (flags[g])
        );
    end

    bctl_rd_mux #(.STAT_W(STAT_W), .VERSION(VERSION)) u_mux (
        .sel   (sel),
        .stat  (stat_sync),
        .flags (flags),
        .rdata (rd_next)
    );

    // Register read data for one cycle after a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
        else             bus_rdata <= '0;
    end

    // Drive the board outputs straight from the flags
    always_comb begin
        post_led_n    = flags[0];
        carrier_rst_n = flags[1];
    end
endmodule

// File: rtl/bctl_regs_chk.sv
// Property checker for bctl_regs, attached by bind below.
module bctl_regs_chk #(
    parameter int         ADDR_W  = 4,
    parameter logic [3:0] VERSION = 4'h3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              post_led_n,
    input logic              carrier_rst_n
);
    logic ctrl_hit;
    always_comb ctrl_hit = (32'(bus_addr) == 32'd8);

    p_reset_vals_r1: assert property (@(posedge clk)
        !rst_n |=> (post_led_n == 1'b0) && (carrier_rst_n == 1'b1));

    p_version_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && 32'(bus_addr) == 32'd0) |=> bus_rdata == {4'h0, VERSION});

    p_led_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctrl_hit && bus_wdata[1]) |=> post_led_n == $past(bus_wdata[0]));

    p_led_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && ctrl_hit && bus_wdata[1]) |=> $stable(post_led_n));

    p_rst_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctrl_hit && bus_wdata[7]) |=> carrier_rst_n == $past(bus_wdata[6]));

    p_rst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && ctrl_hit && bus_wdata[7]) |=> $stable(carrier_rst_n));

    p_ctrl_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ctrl_hit) |=> bus_rdata ==
            {1'b0, $past(carrier_rst_n), 5'b0, $past(post_led_n)});

    p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && 32'(bus_addr) != 32'd0 && 32'(bus_addr) != 32'd4 && !ctrl_hit)
        |=> bus_rdata == 8'h00);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 8'h00);
endmodule

bind bctl_regs bctl_regs_chk #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .post_led_n    (post_led_n),
    .carrier_rst_n (carrier_rst_n)
);

// File: tb/bctl_regs_bench.sv
module bctl_regs_bench;
    localparam int         ADDR_W  = 4;
    localparam int         STAT_W  = 4;
    localparam logic [3:0] VERSION = 4'h3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [STAT_W-1:0] stat_in = '0;
    logic              post_led_n;
    logic              carrier_rst_n;

    int checks = 0;
    int fails  = 0;
    logic rd_d = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    bctl_regs #(.ADDR_W(ADDR_W), .STAT_W(STAT_W), .VERSION(VERSION)) u_bctl_regs (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .stat_in (stat_in), .post_led_n (post_led_n), .carrier_rst_n (carrier_rst_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: a read strobe seen at an edge yields data before the next edge
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                check("scoreboard", 8'hFF, 8'h00);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_pins(input string t, input logic led, input logic rst);
        check({t, " led"}, {7'b0, post_led_n}, {7'b0, led});
        check({t, " rst"}, {7'b0, carrier_rst_n}, {7'b0, rst});
    endtask

    initial begin
        #(5.0 * 150000);
        check("watchdog", 8'h01, 8'h00);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_pins("R1 reset", 1'b0, 1'b1);
        do_read(4'h8, 8'h40, "R1 R8 control after reset");
        do_read(4'h0, {4'h0, VERSION}, "R2 version");
        @(negedge clk);
        check("R11 idle rdata", bus_rdata, 8'h00);

        stat_in = 4'hA;
        repeat (2) @(negedge clk);
        do_read(4'h4, 8'h0A, "R3 status A");
        stat_in = 4'h5;
        repeat (2) @(negedge clk);
        do_read(4'h4, 8'h05, "R3 status 5");

        do_write(4'h8, 8'h03);
        check_pins("R4 led off", 1'b1, 1'b1);
        do_read(4'h8, 8'h41, "R8 control 41");
        do_write(4'h8, 8'h00);
        check_pins("R5 ungated led", 1'b1, 1'b1);
        do_write(4'h8, 8'h02);
        check_pins("R4 led on", 1'b0, 1'b1);

        do_write(4'h8, 8'h80);
        check_pins("R6 R7 assert rst", 1'b0, 1'b0);
        do_read(4'h8, 8'h00, "R6 R8 control 00");
        do_write(4'h8, 8'h43);
        check_pins("R7 ungated rst, gated led", 1'b1, 1'b0);
        do_read(4'h8, 8'h01, "R7 R8 control 01");
        do_write(4'h8, 8'hC0);
        check_pins("R6 R7 release rst", 1'b1, 1'b1);
        do_read(4'h8, 8'h41, "R6 R8 control 41");

        do_write(4'h0, 8'hFF);
        do_write(4'h4, 8'h82);
        do_write(4'hC, 8'h82);
        check_pins("R9 ignored writes", 1'b1, 1'b1);
        do_read(4'h8, 8'h41, "R9 control after stray writes");
        do_read(4'h0, {4'h0, VERSION}, "R9 version after write");
        do_read(4'h4, 8'h05, "R9 status after write");

        for (int a = 0; a < 16; a++) begin
            if (a != 0 && a != 4 && a != 8)
                do_read(ADDR_W'(a), 8'h00, "R10 unmapped offset");
        end
        @(negedge clk);
        check("R11 idle after reads", bus_rdata, 8'h00);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule